// File: doc/BRIEF.md
# Microcontroller Operating Mode Controller

This block decides which operating mode a small microcontroller is in (run, debug halt, wait or stop) and drives the clock-gating and regulator controls that follow from that mode. It watches the power-on reset, the system reset and a debug-initiated reset. When reset is released it samples a mode-strap pin and picks the boot mode. At that moment it also hands the CPU a fixed start address. That address holds a jump instruction (opcode 0xBC followed by a two-byte target), so no vector is fetched.

Once out of reset, the block moves between modes on single-cycle strobes. A halt instruction or a debug halt request leads into debug halt. Wait and stop instructions lead into the two low-power modes. A wake event brings the core back from wait or stop. A debug resume command leaves debug halt. The CPU, the serial debug link, memory and the analog regulator are outside the block. They only consume the mode code and the three enables.

Top module: `mcu_mode_ctl`

## Requirements
- R1: While any reset is active (`por_n` low, `sys_rst_n` low, or the debug reset window), `rst_active` is 1, `mode` is 00, `cpu_clk_en` is 0, `sys_clk_en` is 1 and `reg_standby` is 0.
- R2: At the clock edge where reset is released, a high `ms_pin` selects run mode (`mode` = 00) in the following cycle, whatever the reset cause.
- R3: A low `ms_pin` at release selects debug halt (`mode` = 01) when the reset came from `por_n`. It selects run (00) when the reset came only from `sys_rst_n`.
- R4: A `dbg_force_rst` strobe holds `rst_active` high for exactly FRC_CYC (default 4) cycles, starting at the next edge. A low `ms_pin` at the end of that window selects debug halt (01) without any power-on reset.
- R5: On every reset release, `pc_load` is 1 for exactly one cycle and `boot_pc` reads 0x3FFD. `boot_pc` is 0 until the first release.
- R6: In run mode, `dbg_bkg_req` or `bgnd_exec` gives `mode` 01 in the next cycle. A halt request wins over `stop_exec`, and `stop_exec` (to 11) wins over `wait_exec` (to 10).
- R7: `dbg_bkg_req` also enters debug halt from wait and stop. `bgnd_exec` has no effect outside run mode.
- R8: In wait mode (10), `cpu_clk_en` is 0, `sys_clk_en` is 1 and `reg_standby` is 0.
- R9: In stop mode (11), `cpu_clk_en` is 0, `sys_clk_en` is 0 and `reg_standby` is 1.
- R10: `wake_evt` in wait or stop gives run mode with `cpu_clk_en` and `sys_clk_en` both 1 in the next cycle. `wake_evt` has no effect in run or debug halt.
- R11: `dbg_go` in debug halt returns to run (00) in the next cycle. `dbg_go` has no effect in other modes. `wait_exec`, `stop_exec` and `wake_evt` have no effect in debug halt.
- R12: A reset input asserted in the same cycle as any mode request wins: the next cycle shows `rst_active` = 1 and `mode` = 00.
- R13: The mode encoding is run = 00, debug halt = 01, wait = 10, stop = 11. Run drives enables (cpu, sys, standby) = (1,1,0) and debug halt drives (0,1,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; also the block reset |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| ms_pin | input | 1 | Mode-strap pin level, sampled at reset release |
| dbg_force_rst | input | 1 | Debug forced-reset command strobe |
| dbg_bkg_req | input | 1 | Debug halt request command strobe |
| bgnd_exec | input | 1 | Halt instruction executed strobe |
| wait_exec | input | 1 | Wait instruction executed strobe |
| stop_exec | input | 1 | Stop instruction executed strobe |
| wake_evt | input | 1 | Wake event (interrupt or similar) |
| dbg_go | input | 1 | Debug resume command strobe |
| mode | output | 2 | Current mode code |
| rst_active | output | 1 | Reset currently held |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System (bus and peripheral) clock enable |
| reg_standby | output | 1 | Regulator standby request |
| pc_load | output | 1 | One-cycle pulse at reset release |
| boot_pc | output | PC_W | Start address for the CPU, valid with `pc_load` |

## Verification
Directed sequences release reset under each combination of cause (power-on, system, debug-forced) and strap level. These show whether the strap is honoured only for the causes that permit debug boot. Further directed cases raise conflicting strobes in the same cycle, to expose a wrong priority between reset, halt, stop and wait. They also send each strobe in the modes where it must be ignored. A long seeded random run then mixes rare resets with frequent strobes and compares every cycle against a bench model. This catches cases that only arise in sequence, such as a debug reset arriving inside another reset, or a wake that coincides with a halt request.

// File: rtl/mcu_mode_pkg.sv
// Package: shared mode encoding and clock-control bundle for the mode controller.
// Assumes a 2-bit mode code whose values are decoded by neighbouring logic.
package mcu_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_BKG  = 2'b01,
        MODE_WAIT = 2'b10,
        MODE_STOP = 2'b11
    } mode_e;

    typedef struct packed {
        logic cpu_en;
        logic sys_en;
        logic stby;
    } clk_ctl_t;

endpackage

// File: rtl/mcu_mode_rst_seq.sv
// Reset sequencer: merges power-on, system and debug-forced resets into one
// registered reset, gives the next-cycle reset level for release detection,
// and remembers whether the pending reset may boot into debug halt.
// Assumes all reset inputs are already synchronous to clk.
module mcu_mode_rst_seq #(
    parameter int FRC_CYC = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic frc_rst,
    output logic rst_q,
    output logic rst_nxt,
    output logic bkg_elig
);
    localparam int CNT_W = $clog2(FRC_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             release_now;

    // Next value of the debug reset window counter.
    always_comb begin
        if (!por_n) begin
            cnt_nxt = '0;
        end else if (frc_rst) begin
            cnt_nxt = CNT_W'(FRC_CYC);
        end else if (cnt_q != '0) begin
            cnt_nxt = cnt_q - 1'b1;
        end else begin
            cnt_nxt = '0;
        end
    end

    // Reset level for the coming cycle and release detection.
    always_comb begin
        rst_nxt     = !por_n || !sys_rst_n || (cnt_nxt != '0);
        release_now = rst_q && !rst_nxt;
    end

    // Register reset level, counter and debug-boot eligibility.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q    <= '0;
            rst_q    <= 1'b1;
            bkg_elig <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            rst_q <= rst_nxt;
            if (frc_rst) begin
                bkg_elig <= 1'b1;
            end else if (release_now) begin
                bkg_elig <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mcu_mode_fsm.sv
// Mode state machine: picks the boot mode at reset release from the strap
// pin, then steps between run, debug halt, wait and stop on strobes.
// Priority: reset > halt request > stop > wait. Also issues the start
// address pulse. Assumes strobes are one cycle wide and synchronous.
module mcu_mode_fsm
    import mcu_mode_pkg::*;
#(
    parameter int             PC_W    = 14,
    parameter logic [PC_W-1:0] BOOT_PC = 14'h3FFD
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            rst_q,
    input  logic            rst_nxt,
    input  logic            bkg_elig,
    input  logic            ms_pin,
    input  logic            dbg_bkg_req,
    input  logic            bgnd_exec,
    input  logic            wait_exec,
    input  logic            stop_exec,
    input  logic            wake_evt,
    input  logic            dbg_go,
    output mode_e           mode_q,
    output logic            pc_load_q,
    output logic [PC_W-1:0] boot_pc_q
);
    mode_e mode_nxt;
    mode_e boot_mode;
    logic  halt_req;
    logic  release_now;

    // Boot mode chosen from strap level and reset cause.
    always_comb begin
        release_now = rst_q && !rst_nxt;
        boot_mode   = (!ms_pin && bkg_elig) ? MODE_BKG : MODE_RUN;
    end

    // Steady-state transitions with fixed priority.
    always_comb begin
        halt_req = dbg_bkg_req || ((mode_q == MODE_RUN) && bgnd_exec);
        mode_nxt = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (halt_req)       mode_nxt = MODE_BKG;
                else if (stop_exec) mode_nxt = MODE_STOP;
                else if (wait_exec) mode_nxt = MODE_WAIT;
            end
            MODE_BKG: begin
                if (dbg_go) mode_nxt = MODE_RUN;
            end
            MODE_WAIT, MODE_STOP: begin
                if (halt_req)      mode_nxt = MODE_BKG;
                else if (wake_evt) mode_nxt = MODE_RUN;
            end
            default: mode_nxt = MODE_RUN;
        endcase
    end

    // Mode register and start-address pulse.
    always_ff @(posedge clk) begin
        if (rst_nxt) begin
            mode_q    <= MODE_RUN;
            pc_load_q <= 1'b0;
        end else if (release_now) begin
            mode_q    <= boot_mode;
            pc_load_q <= 1'b1;
        end else begin
            mode_q    <= mode_nxt;
            pc_load_q <= 1'b0;
        end
    end

    // Start address register, loaded at each reset release.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            boot_pc_q <= '0;
        end else if (release_now) begin
            boot_pc_q <= BOOT_PC;
        end
    end

endmodule

// File: rtl/mcu_mode_clk_dec.sv
// Clock and regulator control decode from mode and reset level.
// Assumes mode is held at run while reset is active.
module mcu_mode_clk_dec
    import mcu_mode_pkg::*;
(
    input  mode_e    mode,
    input  logic     rst_q,
    output clk_ctl_t ctl
);
    // Per-mode enables; reset keeps the CPU clock off and the system clock on.
    always_comb begin
        ctl = '{cpu_en: 1'b0, sys_en: 1'b1, stby: 1'b0};
        if (!rst_q) begin
            unique case (mode)
                MODE_RUN:  ctl = '{cpu_en: 1'b1, sys_en: 1'b1, stby: 1'b0};
                MODE_BKG:  ctl = '{cpu_en: 1'b0, sys_en: 1'b1, stby: 1'b0};
                MODE_WAIT: ctl = '{cpu_en: 1'b0, sys_en: 1'b1, stby: 1'b0};
                MODE_STOP: ctl = '{cpu_en: 1'b0, sys_en: 1'b0, stby: 1'b1};
                default:   ctl = '{cpu_en: 1'b0, sys_en: 1'b1, stby: 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/mcu_mode_ctl.sv
// Top: operating mode controller. Wires the reset sequencer, the mode state
// machine and the clock decode. Assumes synchronous inputs; por_n is the
// block's own synchronous active-low reset.
module mcu_mode_ctl
    import mcu_mode_pkg::*;
#(
    parameter int              PC_W    = 14,
    parameter logic [PC_W-1:0] BOOT_PC = 14'h3FFD,
    parameter int              FRC_CYC = 4
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            sys_rst_n,
    input  logic            ms_pin,
    input  logic            dbg_force_rst,
    input  logic            dbg_bkg_req,
    input  logic            bgnd_exec,
    input  logic            wait_exec,
    input  logic            stop_exec,
    input  logic            wake_evt,
    input  logic            dbg_go,
    output logic [1:0]      mode,
    output logic            rst_active,
    output logic            cpu_clk_en,
    output logic            sys_clk_en,
    output logic            reg_standby,
    output logic            pc_load,
    output logic [PC_W-1:0] boot_pc
);
    logic     rst_q;
    logic     rst_nxt;
    logic     bkg_elig;
    mode_e    mode_q;
    clk_ctl_t ctl;

    mcu_mode_rst_seq #(
        .FRC_CYC (FRC_CYC)
    ) u_rst (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .frc_rst   (dbg_force_rst),
        .rst_q     (rst_q),
        .rst_nxt   (rst_nxt),
        .bkg_elig  (bkg_elig)
    );

    mcu_mode_fsm #(
        .PC_W    (PC_W),
        .BOOT_PC (BOOT_PC)
    ) u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .rst_q       (rst_q),
        .rst_nxt     (rst_nxt),
        .bkg_elig    (bkg_elig),
        .ms_pin      (ms_pin),
        .dbg_bkg_req (dbg_bkg_req),
        .bgnd_exec   (bgnd_exec),
        .wait_exec   (wait_exec),
        .stop_exec   (stop_exec),
        .wake_evt    (wake_evt),
        .dbg_go      (dbg_go),
        .mode_q      (mode_q),
        .pc_load_q   (pc_load),
        .boot_pc_q   (boot_pc)
    );

    mcu_mode_clk_dec u_dec (
        .mode  (mode_q),
        .rst_q (rst_q),
        .ctl   (ctl)
    );

    // Drive the flat output ports.
    always_comb begin
        mode        = mode_q;
        rst_active  = rst_q;
        cpu_clk_en  = ctl.cpu_en;
        sys_clk_en  = ctl.sys_en;
        reg_standby = ctl.stby;
    end

endmodule

// File: rtl/mcu_mode_ctl_chk.sv
// Checker: port-level properties of the mode controller, bound to the top.
// Assumes por_n low at time zero.
module mcu_mode_ctl_chk #(
    parameter int              PC_W    = 14,
    parameter logic [PC_W-1:0] BOOT_PC = 14'h3FFD
) (
    input logic            clk,
    input logic            por_n,
    input logic            sys_rst_n,
    input logic            dbg_force_rst,
    input logic            dbg_bkg_req,
    input logic            bgnd_exec,
    input logic            wake_evt,
    input logic            dbg_go,
    input logic [1:0]      mode,
    input logic            rst_active,
    input logic            cpu_clk_en,
    input logic            sys_clk_en,
    input logic            reg_standby,
    input logic            pc_load,
    input logic [PC_W-1:0] boot_pc
);
    logic quiet;
    always_comb quiet = sys_rst_n && !dbg_force_rst && !rst_active;

    AST_RST_STATE: assert property (@(posedge clk) disable iff (!por_n)
        rst_active |-> (mode == 2'b00 && !cpu_clk_en && sys_clk_en)); // R1
    AST_FRC_ENTERS: assert property (@(posedge clk) disable iff (!por_n)
        dbg_force_rst |=> rst_active); // R4
    AST_PC_ON_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_active) |-> pc_load); // R5
    AST_PC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        pc_load |=> !pc_load); // R5
    AST_PC_VALUE: assert property (@(posedge clk) disable iff (!por_n)
        pc_load |-> (boot_pc == BOOT_PC)); // R5
    AST_HALT_INSN: assert property (@(posedge clk) disable iff (!por_n)
        (quiet && mode == 2'b00 && bgnd_exec) |=> (mode == 2'b01)); // R6
    AST_STOP_GATES: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'b11) |-> (!sys_clk_en && reg_standby && !cpu_clk_en)); // R9
    AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (quiet && mode[1] && wake_evt && !dbg_bkg_req) |=> (mode == 2'b00 && cpu_clk_en && sys_clk_en)); // R10
    AST_GO_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (quiet && mode == 2'b01 && dbg_go) |=> (mode == 2'b00)); // R11
    AST_RST_WINS: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> (rst_active && mode == 2'b00)); // R12

endmodule

bind mcu_mode_ctl mcu_mode_ctl_chk #(.PC_W(PC_W), .BOOT_PC(BOOT_PC)) u_chk (.*);

// File: tb/tb_mcu_mode_ctl.sv
`timescale 1ns/1ps
module tb_mcu_mode_ctl;
    localparam int PC_W = 14;
    localparam int FRC  = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0, sys_rst_n = 1'b1, ms_pin = 1'b0, frc = 1'b0;
    logic bkg = 1'b0, bgnd = 1'b0, wt = 1'b0, stp = 1'b0, wake = 1'b0, go = 1'b0;
    logic [1:0]      mode;
    logic            rst_active, cpu_clk_en, sys_clk_en, reg_standby, pc_load;
    logic [PC_W-1:0] boot_pc;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Bench model state
    logic       m_rst = 1'b1, m_elig = 1'b1, m_pcl = 1'b0;
    int         m_cnt = 0;
    logic [1:0] m_mode = 2'b00;
    logic [13:0] m_bpc = '0;

    always #2.5 clk = ~clk;

    mcu_mode_ctl dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .ms_pin(ms_pin),
        .dbg_force_rst(frc), .dbg_bkg_req(bkg), .bgnd_exec(bgnd),
        .wait_exec(wt), .stop_exec(stp), .wake_evt(wake), .dbg_go(go),
        .mode(mode), .rst_active(rst_active), .cpu_clk_en(cpu_clk_en),
        .sys_clk_en(sys_clk_en), .reg_standby(reg_standby),
        .pc_load(pc_load), .boot_pc(boot_pc)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Next mode in steady state, from the requirements (R6, R7, R10, R11).
    function automatic logic [1:0] next_mode(logic [1:0] m);
        case (m)
            2'b00: return (bkg || bgnd) ? 2'b01 : stp ? 2'b11 : wt ? 2'b10 : 2'b00;
            2'b01: return go ? 2'b00 : 2'b01;
            default: return bkg ? 2'b01 : wake ? 2'b00 : m;
        endcase
    endfunction

    task automatic model_step();
        int cn;
        logic rn, rel;
        cn  = !por_n ? 0 : frc ? FRC : (m_cnt > 0 ? m_cnt - 1 : 0);
        rn  = !por_n || !sys_rst_n || (cn != 0);
        rel = m_rst && !rn;
        if (rn)       m_mode = 2'b00;
        else if (rel) m_mode = (!ms_pin && m_elig) ? 2'b01 : 2'b00;
        else          m_mode = next_mode(m_mode);
        if (!por_n || frc) m_elig = 1'b1;
        else if (rel)      m_elig = 1'b0;
        if (!por_n)   m_bpc = '0;
        else if (rel) m_bpc = 14'h3FFD;
        m_pcl = rel;
        m_cnt = cn;
        m_rst = rn;
    endtask

    // One clock: model steps on the edge, outputs compared at the falling edge.
    task automatic cycle(string tag);
        logic cpu, sys, stb;
        @(posedge clk);
        model_step();
        @(negedge clk);
        cpu = !m_rst && m_mode == 2'b00;
        sys = m_mode != 2'b11;
        stb = m_mode == 2'b11;
        chk(tag, {10'd0, mode, rst_active, cpu_clk_en, sys_clk_en, reg_standby, pc_load, boot_pc},
                 {10'd0, m_mode, m_rst, cpu, sys, stb, m_pcl, m_bpc});
    endtask

    task automatic clr();
        frc = 0; bkg = 0; bgnd = 0; wt = 0; stp = 0; wake = 0; go = 0;
    endtask

    task automatic strobe(string tag);
        cycle(tag);
        clr();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) cycle("R1");
        chk("R1", {rst_active, mode, cpu_clk_en, sys_clk_en, reg_standby}, {1'b1, 2'b00, 1'b0, 1'b1, 1'b0});
        chk("R5", boot_pc, 0);
        // R3: power-on release with strap low -> debug halt
        por_n = 1; ms_pin = 0;
        cycle("R3");
        chk("R3", mode, 2'b01);
        chk("R5", {pc_load, boot_pc}, {1'b1, 14'h3FFD});
        cycle("R5");
        chk("R5", pc_load, 0);
        chk("R13", {cpu_clk_en, sys_clk_en, reg_standby}, 3'b010);
        // R11: halt mode ignores wait/stop/wake, go resumes
        wt = 1; strobe("R11"); stp = 1; strobe("R11"); wake = 1; strobe("R11");
        chk("R11", mode, 2'b01);
        go = 1; strobe("R11");
        chk("R11", {mode, cpu_clk_en}, {2'b00, 1'b1});
        go = 1; strobe("R11");
        chk("R11", mode, 2'b00);
        // R10: wake ignored in run, wait then wake
        wake = 1; strobe("R10");
        chk("R10", mode, 2'b00);
        wt = 1; strobe("R8");
        chk("R8", {mode, cpu_clk_en, sys_clk_en, reg_standby}, {2'b10, 3'b010});
        wake = 1; strobe("R10");
        chk("R10", {mode, cpu_clk_en, sys_clk_en}, {2'b00, 2'b11});
        // R6: stop beats wait; R9 stop outputs; R7 bgnd ignored in stop
        stp = 1; wt = 1; strobe("R6");
        chk("R6", mode, 2'b11);
        chk("R9", {cpu_clk_en, sys_clk_en, reg_standby}, 3'b001);
        bgnd = 1; strobe("R7");
        chk("R7", mode, 2'b11);
        bkg = 1; strobe("R7");
        chk("R7", mode, 2'b01);
        go = 1; strobe("R11");
        bkg = 1; stp = 1; wt = 1; strobe("R6");
        chk("R6", mode, 2'b01);
        go = 1; strobe("R11");
        bgnd = 1; stp = 1; strobe("R6");
        chk("R6", mode, 2'b01);
        go = 1; strobe("R11");
        wt = 1; strobe("R7"); bgnd = 1; strobe("R7");
        chk("R7", mode, 2'b10);
        bkg = 1; strobe("R7");
        chk("R7", mode, 2'b01);
        go = 1; strobe("R11");
        // R3: system reset with strap low -> run
        sys_rst_n = 0; ms_pin = 0;
        cycle("R1"); cycle("R1");
        sys_rst_n = 1;
        cycle("R3");
        chk("R3", {mode, pc_load}, {2'b00, 1'b1});
        // R4: forced reset window length and debug boot
        frc = 1; ms_pin = 0;
        begin
            int hi = 0;
            strobe("R4");
            while (rst_active && hi < 20) begin
                hi++;
                cycle("R4");
            end
            chk("R4", hi, FRC);
        end
        chk("R4", mode, 2'b01);
        // R2: forced reset with strap high -> run
        frc = 1; ms_pin = 1;
        strobe("R2");
        repeat (FRC) cycle("R2");
        chk("R2", {mode, rst_active}, {2'b00, 1'b0});
        // R2: power-on with strap high -> run
        por_n = 0; cycle("R2"); por_n = 1; cycle("R2");
        chk("R2", mode, 2'b00);
        // R12: reset beats concurrent requests
        sys_rst_n = 0; bkg = 1; stp = 1; wt = 1;
        strobe("R12");
        chk("R12", {rst_active, mode}, {1'b1, 2'b00});
        sys_rst_n = 1; cycle("R12");
        stp = 1; strobe("R12");
        frc = 1; wake = 1; strobe("R12");
        chk("R12", {rst_active, mode}, {1'b1, 2'b00});
        repeat (FRC + 1) cycle("R12");
        // R13: seeded random mix against the model
        for (int i = 0; i < 4000; i++) begin
            por_n     = ($urandom_range(0, 299) != 0);
            sys_rst_n = ($urandom_range(0, 149) != 0);
            frc       = ($urandom_range(0, 149) == 0);
            ms_pin    = $urandom_range(0, 1);
            bkg       = ($urandom_range(0, 11) == 0);
            bgnd      = ($urandom_range(0, 11) == 0);
            wt        = ($urandom_range(0, 5) == 0);
            stp       = ($urandom_range(0, 7) == 0);
            wake      = ($urandom_range(0, 4) == 0);
            go        = ($urandom_range(0, 4) == 0);
            cycle("R13");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule